// File: doc/BRIEF.md
# DMA Queue Doorbell and Completion Controller

This block runs one queue of a descriptor-ring DMA engine. Software programs it through a simple memory-mapped register port: a control word, the 64-bit ring base, the ring depth, a tail index, and the 64-bit address where the consumed head is to be written back. Writing the tail index rings the doorbell. While the queue runs and the head index trails the tail, the block asks the datapath to fetch the descriptor at the head slot. It keeps exactly one descriptor in flight. When that descriptor is reported done, it advances the head.

Each completion can be reported in two ways. One is a request to write the new head value to the writeback address. The other is an interrupt request. Each way needs both its enable bit in the control word and its flag in the finished descriptor. Fetching, writeback and interrupt are each a plain request that the block holds until it is acknowledged. A clear register returns the head, the tail and all pending requests to their idle state. The configuration is left untouched.

Top module: `dmaq_ctrl`

## Requirements
- R1: After reset every request output is low and every register reads 0. Register offsets are: control 0x00, ring base low 0x08, ring base high 0x0C, ring depth 0x10, tail 0x14, writeback address low 0x20, writeback address high 0x24, coalescing delay 0x28, transfer length 0x44, queue clear 0x48. Each register except the queue clear reads back the value written. Control bits are: bit 0 run, bit 1 writeback enable, bit 2 interrupt enable.
- R2: A fetch request is raised only while run is set and head differs from tail. A write to the tail register is the doorbell that makes them differ.
- R3: The fetch address equals the 64-bit ring base plus the head index times 32, and fetch_idx carries the head index.
- R4: A raised fetch request holds its index until fetch_ack. No new fetch starts until the in-flight descriptor has completed and its reporting has finished.
- R5: A completion advances the head by one. The head wraps to 0 when it reaches the ring depth.
- R6: Clearing run stops new fetches. Setting it again resumes fetching from the current head.
- R7: A writeback request is raised only when control bit 1 and the descriptor's writeback flag are both set. It carries the 64-bit writeback address and the head value after the advance, and it is held until wb_ack.
- R8: An interrupt request is raised only when control bit 2 and the descriptor's interrupt flag are both set. It is held until irq_ack.
- R9: When both reports are due, the writeback request is completed (acknowledged) before the interrupt request rises.
- R10: Writing 1 to bit 0 of the queue clear register sets head and tail to 0 and drops any pending fetch, writeback or interrupt request. All configuration registers keep their values.
- R11: A completion pulse that arrives while no descriptor is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | RAW | Register write byte offset |
| reg_wr_data | input | DW | Register write data |
| reg_rd_addr | input | RAW | Register read byte offset |
| reg_rd_data | output | DW | Register read data (combinational) |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 2*DW | Descriptor address |
| fetch_idx | output | IDX_W | Ring slot being fetched |
| fetch_ack | input | 1 | Fetch accepted |
| cmpl_valid | input | 1 | In-flight descriptor finished |
| cmpl_wb_en | input | 1 | Descriptor asks for head writeback |
| cmpl_irq_en | input | 1 | Descriptor asks for interrupt |
| wb_req | output | 1 | Head writeback request |
| wb_addr | output | 2*DW | Writeback target address |
| wb_data | output | IDX_W | Consumed head value |
| wb_ack | input | 1 | Writeback accepted |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt accepted |

## Verification
Two events can land on the same clock edge: a descriptor completion, which advances the head, and a doorbell write, which moves the tail. The bench's datapath model raises cmpl_valid and drives a tail write in the same cycle. The scoreboard then expects the full report for the finished slot first. After that it expects the next fetch to target the following slot, with the advanced head and the new tail both in effect. A tail readback after the run confirms that the write was not lost.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ  = 2'd1,
    F_WAIT = 2'd2
  } fetch_st_e;

  typedef enum logic [1:0] {
    R_IDLE = 2'd0,
    R_WB   = 2'd1,
    R_IRQ  = 2'd2
  } rep_st_e;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_RING_LO  = 8'h08;
  localparam logic [7:0] OFS_RING_HI  = 8'h0C;
  localparam logic [7:0] OFS_DEPTH    = 8'h10;
  localparam logic [7:0] OFS_TAIL     = 8'h14;
  localparam logic [7:0] OFS_DONE_LO  = 8'h20;
  localparam logic [7:0] OFS_DONE_HI  = 8'h24;
  localparam logic [7:0] OFS_COALESCE = 8'h28;
  localparam logic [7:0] OFS_XFER_LEN = 8'h44;
  localparam logic [7:0] OFS_QCLR     = 8'h48;

  // control word bit positions
  localparam int CB_RUN = 0;
  localparam int CB_WB  = 1;
  localparam int CB_IRQ = 2;
  localparam int CTRL_W = 3;

endpackage

// File: rtl/dmaq_regs.sv
module dmaq_regs
  import dmaq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int RAW   = 8,
  parameter int IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RAW-1:0]    wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [RAW-1:0]    rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              run,
  output logic              wb_on,
  output logic              irq_on,
  output logic [2*DW-1:0]   ring_base,
  output logic [IDX_W-1:0]  ring_size,
  output logic [IDX_W-1:0]  tail,
  output logic [2*DW-1:0]   done_addr,
  output logic              qclr
);

  localparam int PAD = DW - IDX_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     rlo_q, rlo_d, rhi_q, rhi_d;
  logic [DW-1:0]     dlo_q, dlo_d, dhi_q, dhi_d;
  logic [DW-1:0]     coal_q, coal_d, xfer_q, xfer_d;
  logic [IDX_W-1:0]  size_q, size_d, tail_q, tail_d;
  logic              load;

  assign qclr = wr_en && (wr_addr == RAW'(OFS_QCLR)) && wr_data[0];
  assign load = wr_en || qclr;

  always_comb begin
    ctrl_d = ctrl_q;
    rlo_d  = rlo_q;
    rhi_d  = rhi_q;
    dlo_d  = dlo_q;
    dhi_d  = dhi_q;
    coal_d = coal_q;
    xfer_d = xfer_q;
    size_d = size_q;
    tail_d = tail_q;
    if (wr_en) begin
      case (wr_addr)
        RAW'(OFS_CTRL):     ctrl_d = wr_data[CTRL_W-1:0];
        RAW'(OFS_RING_LO):  rlo_d  = wr_data;
        RAW'(OFS_RING_HI):  rhi_d  = wr_data;
        RAW'(OFS_DEPTH):    size_d = wr_data[IDX_W-1:0];
        RAW'(OFS_TAIL):     tail_d = wr_data[IDX_W-1:0];
        RAW'(OFS_DONE_LO):  dlo_d  = wr_data;
        RAW'(OFS_DONE_HI):  dhi_d  = wr_data;
        RAW'(OFS_COALESCE): coal_d = wr_data;
        RAW'(OFS_XFER_LEN): xfer_d = wr_data;
        default: ;
      endcase
    end
    if (qclr) tail_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rlo_q  <= '0;
      rhi_q  <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      coal_q <= '0;
      xfer_q <= '0;
      size_q <= '0;
      tail_q <= '0;
    end else if (load) begin
      ctrl_q <= ctrl_d;
      rlo_q  <= rlo_d;
      rhi_q  <= rhi_d;
      dlo_q  <= dlo_d;
      dhi_q  <= dhi_d;
      coal_q <= coal_d;
      xfer_q <= xfer_d;
      size_q <= size_d;
      tail_q <= tail_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RAW'(OFS_CTRL):     rd_data = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      RAW'(OFS_RING_LO):  rd_data = rlo_q;
      RAW'(OFS_RING_HI):  rd_data = rhi_q;
      RAW'(OFS_DEPTH):    rd_data = {{PAD{1'b0}}, size_q};
      RAW'(OFS_TAIL):     rd_data = {{PAD{1'b0}}, tail_q};
      RAW'(OFS_DONE_LO):  rd_data = dlo_q;
      RAW'(OFS_DONE_HI):  rd_data = dhi_q;
      RAW'(OFS_COALESCE): rd_data = coal_q;
      RAW'(OFS_XFER_LEN): rd_data = xfer_q;
      default:            rd_data = '0;
    endcase
  end

  assign run       = ctrl_q[CB_RUN];
  assign wb_on     = ctrl_q[CB_WB];
  assign irq_on    = ctrl_q[CB_IRQ];
  assign ring_base = {rhi_q, rlo_q};
  assign done_addr = {dhi_q, dlo_q};
  assign ring_size = size_q;
  assign tail      = tail_q;

  // R10: a clear leaves the tail at zero on the next cycle
  p_tail_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    qclr |=> (tail_q == '0));

endmodule

// File: rtl/dmaq_fetch.sv
module dmaq_fetch
  import dmaq_pkg::*;
#(
  parameter int AW         = 64,
  parameter int IDX_W      = 16,
  parameter int DESC_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IDX_W-1:0] tail,
  input  logic [IDX_W-1:0] ring_size,
  input  logic [AW-1:0]    ring_base,
  input  logic             rep_idle,
  input  logic             qclr,
  input  logic             fetch_ack,
  input  logic             cmpl_valid,
  output logic             fetch_req,
  output logic [AW-1:0]    fetch_addr,
  output logic [IDX_W-1:0] fetch_idx,
  output logic             cmpl_take,
  output logic [IDX_W-1:0] head_adv
);

  localparam int SH = $clog2(DESC_BYTES);

  fetch_st_e        st_q, st_d;
  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] head_inc;
  logic             pending;

  assign head_inc  = head_q + 1'b1;
  assign head_adv  = (head_inc == ring_size) ? '0 : head_inc;
  assign pending   = run && (head_q != tail) && rep_idle;
  assign cmpl_take = (st_q == F_WAIT) && cmpl_valid;

  always_comb begin
    st_d   = st_q;
    head_d = head_q;
    case (st_q)
      F_IDLE: if (pending) st_d = F_REQ;
      F_REQ:  if (fetch_ack) st_d = F_WAIT;
      F_WAIT: if (cmpl_valid) begin
        st_d   = F_IDLE;
        head_d = head_adv;
      end
      default: st_d = F_IDLE;
    endcase
    if (qclr) begin
      st_d   = F_IDLE;
      head_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      head_q <= '0;
    end else begin
      st_q   <= st_d;
      head_q <= head_d;
    end
  end

  assign fetch_req  = (st_q == F_REQ);
  assign fetch_idx  = head_q;
  assign fetch_addr = ring_base + (AW'(head_q) << SH);

  // R2: a new fetch only follows a cycle with run set and a non-empty ring
  p_no_empty_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(run && (head_q != tail)));

  // R4: request and slot hold until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack && !qclr) |=> (fetch_req && $stable(fetch_idx)));

  // R5: the head only steps by one or wraps to zero
  p_head_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q != $past(head_q)) |-> ((head_q == '0) || (head_q == IDX_W'($past(head_q) + 1'b1))));

  // R10: a clear drops the request and zeroes the head
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    qclr |=> (!fetch_req && (head_q == '0)));

endmodule

// File: rtl/dmaq_report.sv
module dmaq_report
  import dmaq_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qclr,
  input  logic             cmpl_take,
  input  logic             desc_wb,
  input  logic             desc_irq,
  input  logic             wb_on,
  input  logic             irq_on,
  input  logic [IDX_W-1:0] head_adv,
  input  logic [AW-1:0]    done_addr,
  input  logic             wb_ack,
  input  logic             irq_ack,
  output logic             wb_req,
  output logic [AW-1:0]    wb_addr,
  output logic [IDX_W-1:0] wb_data,
  output logic             irq_req,
  output logic             idle
);

  rep_st_e          st_q, st_d;
  logic             ipend_q, ipend_d;
  logic [IDX_W-1:0] data_q, data_d;
  logic             wb_go, irq_go, data_en;

  assign wb_go   = wb_on && desc_wb;
  assign irq_go  = irq_on && desc_irq;
  assign data_en = cmpl_take && (st_q == R_IDLE);

  always_comb begin
    st_d    = st_q;
    ipend_d = ipend_q;
    data_d  = data_q;
    case (st_q)
      R_IDLE: if (cmpl_take) begin
        data_d  = head_adv;
        ipend_d = irq_go;
        if (wb_go)       st_d = R_WB;
        else if (irq_go) st_d = R_IRQ;
      end
      R_WB: if (wb_ack) begin
        st_d    = ipend_q ? R_IRQ : R_IDLE;
        ipend_d = 1'b0;
      end
      R_IRQ: if (irq_ack) st_d = R_IDLE;
      default: st_d = R_IDLE;
    endcase
    if (qclr) begin
      st_d    = R_IDLE;
      ipend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= R_IDLE;
      ipend_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ipend_q <= ipend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign wb_req  = (st_q == R_WB);
  assign irq_req = (st_q == R_IRQ);
  assign wb_addr = done_addr;
  assign wb_data = data_q;
  assign idle    = (st_q == R_IDLE);

  // R7: writeback only for a completion with both enables
  p_wb_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> $past(cmpl_take && wb_on && desc_wb));

  // R7: writeback held with stable data until acknowledged
  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack && !qclr) |=> (wb_req && $stable(wb_data)));

  // R8: interrupt held until acknowledged
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack && !qclr) |=> irq_req);

  // R9: an interrupt that follows a writeback waits for its acknowledge
  p_wb_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req) && $past(wb_req)) |-> $past(wb_ack));

endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
  import dmaq_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RAW        = 8,
  parameter int IDX_W      = 16,
  parameter int DESC_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [RAW-1:0]    reg_wr_addr,
  input  logic [DW-1:0]     reg_wr_data,
  input  logic [RAW-1:0]    reg_rd_addr,
  output logic [DW-1:0]     reg_rd_data,
  output logic              fetch_req,
  output logic [2*DW-1:0]   fetch_addr,
  output logic [IDX_W-1:0]  fetch_idx,
  input  logic              fetch_ack,
  input  logic              cmpl_valid,
  input  logic              cmpl_wb_en,
  input  logic              cmpl_irq_en,
  output logic              wb_req,
  output logic [2*DW-1:0]   wb_addr,
  output logic [IDX_W-1:0]  wb_data,
  input  logic              wb_ack,
  output logic              irq_req,
  input  logic              irq_ack
);

  localparam int AW = 2 * DW;

  logic [1:0]       rsync_q;
  logic             srst_n;
  logic             run, wb_on, irq_on, qclr;
  logic [AW-1:0]    ring_base, done_addr;
  logic [IDX_W-1:0] ring_size, tail, head_adv;
  logic             rep_idle, cmpl_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  dmaq_regs #(.DW(DW), .RAW(RAW), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .rd_addr   (reg_rd_addr),
    .rd_data   (reg_rd_data),
    .run       (run),
    .wb_on     (wb_on),
    .irq_on    (irq_on),
    .ring_base (ring_base),
    .ring_size (ring_size),
    .tail      (tail),
    .done_addr (done_addr),
    .qclr      (qclr)
  );

  dmaq_fetch #(.AW(AW), .IDX_W(IDX_W), .DESC_BYTES(DESC_BYTES)) u_fetch (
    .clk        (clk),
    .rst_n      (srst_n),
    .run        (run),
    .tail       (tail),
    .ring_size  (ring_size),
    .ring_base  (ring_base),
    .rep_idle   (rep_idle),
    .qclr       (qclr),
    .fetch_ack  (fetch_ack),
    .cmpl_valid (cmpl_valid),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .fetch_idx  (fetch_idx),
    .cmpl_take  (cmpl_take),
    .head_adv   (head_adv)
  );

  dmaq_report #(.AW(AW), .IDX_W(IDX_W)) u_report (
    .clk       (clk),
    .rst_n     (srst_n),
    .qclr      (qclr),
    .cmpl_take (cmpl_take),
    .desc_wb   (cmpl_wb_en),
    .desc_irq  (cmpl_irq_en),
    .wb_on     (wb_on),
    .irq_on    (irq_on),
    .head_adv  (head_adv),
    .done_addr (done_addr),
    .wb_ack    (wb_ack),
    .irq_ack   (irq_ack),
    .wb_req    (wb_req),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .irq_req   (irq_req),
    .idle      (rep_idle)
  );

  // R4: a fetch is never outstanding while a report is pending
  p_one_inflight_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(fetch_req) |-> !(wb_req || irq_req));

  // R11: completions outside an in-flight window change nothing
  p_stray_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (cmpl_valid && !cmpl_take && rep_idle && !qclr) |=> (!wb_req && !irq_req));

endmodule

// File: tb/dmaq_ctrl_tb.sv
module dmaq_ctrl_tb;

  localparam int IDX_W = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_addr, reg_rd_addr;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        fetch_req, fetch_ack;
  logic [63:0] fetch_addr, wb_addr;
  logic [IDX_W-1:0] fetch_idx, wb_data;
  logic        cmpl_valid, cmpl_wb_en, cmpl_irq_en;
  logic        wb_req, wb_ack, irq_req, irq_ack;

  always #10 clk = ~clk;

  dmaq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_idx(fetch_idx), .fetch_ack(fetch_ack),
    .cmpl_valid(cmpl_valid), .cmpl_wb_en(cmpl_wb_en), .cmpl_irq_en(cmpl_irq_en),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack),
    .irq_req(irq_req), .irq_ack(irq_ack)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [65:0] expq[$];
  logic [63:0] base_m  = 64'h0000_0001_0000_1000;
  logic [63:0] wbadr_m = 64'h0000_0002_0000_0040;
  int  size_m = 4;
  int  tail_m = 0;
  bit  wb_m = 0, irq_m = 0;
  bit  wbf[16];
  bit  irqf[16];
  bit  hold_ack = 0, stray = 0, db_at_cmpl = 0, db_clear = 0;
  logic [31:0] db_val;
  int  ev_seen = 0;
  int  cmpl_cnt = 0;
  int  cur_idx = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic match(input logic [1:0] k, input logic [63:0] v, input string tag);
    logic [65:0] e;
    checks++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected act=%h exp=none", tag, v);
    end else begin
      e = expq.pop_front();
      if (e != {k, v}) begin
        fails++;
        $display("FAIL %s act=%h_%h exp=%h_%h", tag, k, v, e[65:64], e[63:0]);
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard monitor and datapath model
  always @(negedge clk) begin
    if (rst_n) begin
      fetch_ack  = 1'b0;
      wb_ack     = 1'b0;
      irq_ack    = 1'b0;
      cmpl_valid = 1'b0;
      if (db_clear) begin
        reg_wr_en = 1'b0;
        db_clear  = 0;
      end
      if (fetch_req && !hold_ack) begin
        ev_seen++;
        match(2'd1, fetch_addr, "R3 fetch address");
        fetch_ack = 1'b1;
        cur_idx   = int'(fetch_idx);
        cmpl_cnt  = 3;
      end else if (cmpl_cnt > 0) begin
        cmpl_cnt--;
        if (cmpl_cnt == 0) begin
          cmpl_valid  = 1'b1;
          cmpl_wb_en  = wbf[cur_idx & 15];
          cmpl_irq_en = irqf[cur_idx & 15];
          if (db_at_cmpl) begin
            reg_wr_en   = 1'b1;
            reg_wr_addr = 8'h14;
            reg_wr_data = db_val;
            db_at_cmpl  = 0;
            db_clear    = 1;
          end
        end
      end
      if (stray) begin
        cmpl_valid  = 1'b1;
        cmpl_wb_en  = 1'b1;
        cmpl_irq_en = 1'b1;
        stray       = 0;
      end
      if (wb_req) begin
        ev_seen++;
        match(2'd2, 64'(wb_data), "R7 writeback head");
        chk(wb_addr == wbadr_m, "R7 writeback address", wb_addr, wbadr_m);
        wb_ack = 1'b1;
      end
      if (irq_req) begin
        ev_seen++;
        match(2'd3, 64'd0, "R9 interrupt after writeback");
        irq_ack = 1'b1;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_wr_addr = a;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    #1;
    d = reg_rd_data;
  endtask

  task automatic expect_desc(input int idx);
    expq.push_back({2'd1, base_m + 64'(idx) * 64'd32});
    if (wb_m && wbf[idx]) expq.push_back({2'd2, 64'((idx + 1) % size_m)});
    if (irq_m && irqf[idx]) expq.push_back({2'd3, 64'd0});
  endtask

  task automatic post(input int n);
    for (int i = 0; i < n; i++) begin
      expect_desc(tail_m);
      tail_m = (tail_m + 1) % size_m;
    end
    wr(8'h14, 32'(tail_m));
  endtask

  task automatic set_ctrl(input bit r, input bit w, input bit q);
    wb_m  = w;
    irq_m = q;
    wr(8'h00, {29'd0, q, w, r});
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((expq.size() != 0 || fetch_req || wb_req || irq_req || cmpl_cnt != 0) && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, tag, 64'(expq.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int seen;
    logic [63:0] held_addr;
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; reg_rd_addr = '0;
    fetch_ack = 1'b0; wb_ack = 1'b0; irq_ack = 1'b0;
    cmpl_valid = 1'b0; cmpl_wb_en = 1'b0; cmpl_irq_en = 1'b0;
    db_val = '0;
    repeat (3) @(negedge clk);
    chk(!fetch_req && !wb_req && !irq_req, "R1 outputs idle in reset",
        {61'd0, fetch_req, wb_req, irq_req}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h00, d); chk(d == 0, "R1 control reset value", 64'(d), 64'd0);
    rd(8'h14, d); chk(d == 0, "R1 tail reset value", 64'(d), 64'd0);

    // initialise the queue: clear, tail to 0, then configuration
    wr(8'h48, 32'd1);
    wr(8'h14, 32'd0);
    wr(8'h08, base_m[31:0]);
    wr(8'h0C, base_m[63:32]);
    wr(8'h10, 32'(size_m));
    wr(8'h20, wbadr_m[31:0]);
    wr(8'h24, wbadr_m[63:32]);
    wr(8'h28, 32'h55);
    wr(8'h44, 32'h1000);
    rd(8'h0C, d); chk(d == base_m[63:32], "R1 ring base high readback", 64'(d), 64'(base_m[63:32]));
    rd(8'h10, d); chk(d == 32'(size_m), "R1 ring depth readback", 64'(d), 64'(size_m));
    rd(8'h28, d); chk(d == 32'h55, "R1 coalescing readback", 64'(d), 64'h55);
    rd(8'h44, d); chk(d == 32'h1000, "R1 transfer length readback", 64'(d), 64'h1000);
    set_ctrl(1, 1, 1);
    rd(8'h00, d); chk(d == 32'h7, "R1 control readback", 64'(d), 64'h7);

    // R2: enabled but empty ring issues nothing
    repeat (10) @(negedge clk);
    chk(ev_seen == 0, "R2 no fetch on empty ring", 64'(ev_seen), 64'd0);

    wbf[0] = 1; irqf[0] = 1;
    wbf[1] = 1; irqf[1] = 0;
    wbf[2] = 0; irqf[2] = 1;
    wbf[3] = 0; irqf[3] = 0;
    post(3);
    drain("R2 doorbell runs three descriptors");

    // R5: slot 3 wraps the head to 0, then slots 0 and 1 again
    post(1);
    post(2);
    drain("R5 head wrap at ring depth");

    // R7 / R8 gating by control enables
    wbf[2] = 1;
    set_ctrl(1, 0, 1);
    post(1);
    drain("R7 writeback suppressed when control bit clear");
    wbf[3] = 1; irqf[3] = 1;
    set_ctrl(1, 1, 0);
    post(1);
    drain("R8 interrupt suppressed when control bit clear");
    set_ctrl(1, 1, 1);

    // R6: run cleared blocks fetching, setting it resumes
    set_ctrl(0, 1, 1);
    seen = ev_seen;
    post(1);
    repeat (30) @(negedge clk);
    chk(ev_seen == seen, "R6 no fetch while run clear", 64'(ev_seen), 64'(seen));
    set_ctrl(1, 1, 1);
    drain("R6 fetch resumes when run set");

    // R11: stray completion while idle; head must stay at 1
    seen = ev_seen;
    stray = 1;
    repeat (10) @(negedge clk);
    chk(ev_seen == seen, "R11 stray completion ignored", 64'(ev_seen), 64'(seen));
    post(1);
    drain("R11 head unchanged after stray completion");

    // same-cycle completion and doorbell: slot 2 completes as tail moves past slot 3
    wbf[2] = 1; irqf[2] = 1;
    expect_desc(2);
    expect_desc(3);
    tail_m = 0;
    db_val = 32'd0;
    db_at_cmpl = 1;
    wr(8'h14, 32'd3);
    drain("R2 doorbell on completion cycle");
    rd(8'h14, d); chk(d == 0, "R2 tail write on completion cycle kept", 64'(d), 64'd0);

    // R10: move head to 1, hold a fetch of slot 1, then clear
    post(1);
    drain("R10 setup");
    hold_ack = 1;
    wr(8'h14, 32'd2);
    repeat (3) @(negedge clk);
    held_addr = fetch_addr;
    chk(fetch_req == 1'b1, "R4 fetch raised and waiting", 64'(fetch_req), 64'd1);
    repeat (5) @(negedge clk);
    chk(fetch_req && fetch_addr == held_addr, "R4 request held until ack", fetch_addr, held_addr);
    wr(8'h48, 32'd1);
    chk(fetch_req == 1'b0, "R10 clear drops pending fetch", 64'(fetch_req), 64'd0);
    rd(8'h14, d); chk(d == 0, "R10 tail cleared", 64'(d), 64'd0);
    rd(8'h08, d); chk(d == base_m[31:0], "R10 ring base kept", 64'(d), 64'(base_m[31:0]));
    rd(8'h00, d); chk(d == 32'h7, "R10 control kept", 64'(d), 64'h7);
    hold_ack = 0;
    tail_m = 0;
    post(1);
    drain("R10 head restarts at slot 0");

    finished = 1;
    finish_run();
  end

endmodule